// File: doc/BRIEF.md
# MSI Directory Home Controller

This block is the home node of a two-level coherent memory system. It owns a small on-chip word array and keeps a directory record for every child cache: the coherence state the home believes each child holds for every word, and an optional wait tag. The wait tag marks a downgrade that the home has asked for and not yet seen answered. Children reach the home through two inbound queues each. One queue carries upgrade requests and the other carries downgrade responses, which are either answers to the home's requests or voluntary evictions. The home sends one outbound message per cycle. That message is either an upgrade grant to the requester or a downgrade request to a sibling.

Each cycle the controller looks at the queue heads and serves one message. Responses always come before requests. Among the children that are requesting, a rotating pointer picks one. A request is granted only when the word is free of pending downgrades and every sibling is compatible with the requested state. If it is not granted, the request stays at the head of its queue. The controller then sends a downgrade to one sibling that is still too high and has no wait pending, and the request is retried on a later turn.

Top module: `msi_home_dir`

## Requirements
- R1: States are encoded I=0, S=1, M=2. Two records are compatible unless one is M and the other is S or M. A request for target y (S or M) from child c is granted only when every other child's record for that word is compatible with y. A grant appears as out_valid=1, out_grant=1, out_dst=c, out_state=y.
- R2: A grant carries the memory word, with out_has_data=1 and out_data=word, only when child c is recorded in I. Otherwise out_has_data=0 and out_data=0. The grant sets c's record to y and pulses req_ready[c].
- R3: A blocked request produces a downgrade request, with out_grant=0 and out_state set to the required level. That level is I for an M request and S for an S request. The downgrade goes to the lowest-indexed sibling recorded above that level that has no wait pending. Its wait tag is set to the required level, and the request is not dequeued.
- R4: While any child has a wait pending on the word, no grant is issued for that word. When no sibling is eligible for a downgrade, the request produces no output.
- R5: A response from child k always pulses rsp_ready[k] and produces no output. It writes its data into the word only if k was recorded in M, and it then sets k's record to the reported state.
- R6: A response reporting state y clears k's wait tag x only when x >= y. Otherwise the wait stays pending.
- R7: When any response is present, no request is served in that cycle, and at most one queue is dequeued per cycle.
- R8: Requests are picked round-robin. The search starts at the child after the last one whose request was served.
- R9: At most one child is recorded in M for any word.
- R10: After reset, every record is I, no wait is pending, every word is zero and the output is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Request queue head valid, one bit per child |
| req_addr | input | N*AW | Request word address per child |
| req_state | input | 2*N | Requested target state per child |
| req_ready | output | N | Dequeue pulse for the request queue |
| rsp_valid | input | N | Response queue head valid, one bit per child |
| rsp_addr | input | N*AW | Response word address per child |
| rsp_state | input | 2*N | State reported by the child |
| rsp_data | input | N*DW | Write-back data per child |
| rsp_ready | output | N | Dequeue pulse for the response queue |
| out_valid | output | 1 | Outbound message valid |
| out_grant | output | 1 | 1 = upgrade grant, 0 = downgrade request |
| out_dst | output | CW | Destination child |
| out_addr | output | AW | Word address |
| out_state | output | 2 | Granted or required state |
| out_has_data | output | 1 | Message carries the memory word |
| out_data | output | DW | Memory word or zero |

## Verification
The main stimulus walks a single word through several patterns:
- A cold M request, which tells a data-bearing grant from a bare one.
- Two shared readers followed by a writer, which tells lowest-sibling downgrade ordering and wait-tag skipping from a grant that was issued too early.
- A writer followed by a reader, which tells an S-level downgrade from an I-level one.
- Write-backs from children recorded in S and in M, which show whether memory is written only for the M owner.

A response that reports a higher state than the pending tag separates the x >= y clear rule from an unconditional clear. Directed cases then put a response and a request in the same cycle, and keep two requesters active across two cycles, so that response priority and rotation are visible against fixed-priority behaviour.

// File: rtl/msi_home_dir.sv
module msi_home_dir #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_valid,
  input  logic [N*AW-1:0]   req_addr,
  input  logic [2*N-1:0]    req_state,
  output logic [N-1:0]      req_ready,
  input  logic [N-1:0]      rsp_valid,
  input  logic [N*AW-1:0]   rsp_addr,
  input  logic [2*N-1:0]    rsp_state,
  input  logic [N*DW-1:0]   rsp_data,
  output logic [N-1:0]      rsp_ready,
  output logic              out_valid,
  output logic              out_grant,
  output logic [$clog2(N)-1:0] out_dst,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_state,
  output logic              out_has_data,
  output logic [DW-1:0]     out_data
);
  localparam int CW = $clog2(N);
  localparam int WORDS = 1 << AW;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;

  logic [DW-1:0] mem [WORDS];
  logic [1:0]    cst [N][WORDS];
  logic          wv  [N][WORDS];
  logic [1:0]    wst [N][WORDS];
  logic [CW-1:0] ptr;

  logic          rsp_hit, req_hit, busy, compat, dn_hit, grant;
  logic [CW-1:0] rsp_idx, req_idx, dn_idx;
  logic [AW-1:0] ra, pa;
  logic [1:0]    ry, py, need;
  logic [DW-1:0] pd;

  always_comb begin
    rsp_hit = 1'b0;
    rsp_idx = '0;
    for (int k = N-1; k >= 0; k--)
      if (rsp_valid[k]) begin
        rsp_hit = 1'b1;
        rsp_idx = CW'(k);
      end
    req_hit = 1'b0;
    req_idx = '0;
    for (int k = N-1; k >= 0; k--) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (req_valid[j]) begin
        req_hit = 1'b1;
        req_idx = CW'(j);
      end
    end
  end

  assign pa = rsp_addr[rsp_idx*AW +: AW];
  assign py = rsp_state[rsp_idx*2 +: 2];
  assign pd = rsp_data[rsp_idx*DW +: DW];
  assign ra = req_addr[req_idx*AW +: AW];
  assign ry = req_state[req_idx*2 +: 2];
  assign need = (ry == ST_M) ? ST_I : ST_S;

  always_comb begin
    busy   = 1'b0;
    compat = 1'b1;
    dn_hit = 1'b0;
    dn_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (wv[i][ra]) busy = 1'b1;
      if (CW'(i) != req_idx) begin
        if ((cst[i][ra] == ST_M && ry != ST_I) || (ry == ST_M && cst[i][ra] != ST_I))
          compat = 1'b0;
        if (cst[i][ra] > need && !wv[i][ra]) begin
          dn_hit = 1'b1;
          dn_idx = CW'(i);
        end
      end
    end
  end

  assign grant = !rsp_hit && req_hit && !busy && compat;

  always_comb begin
    req_ready = '0;
    rsp_ready = '0;
    if (rsp_hit) rsp_ready[rsp_idx] = 1'b1;
    else if (grant) req_ready[req_idx] = 1'b1;
  end

  assign out_valid    = !rsp_hit && req_hit && (grant || dn_hit);
  assign out_grant    = grant;
  assign out_dst      = grant ? req_idx : dn_idx;
  assign out_addr     = ra;
  assign out_state    = grant ? ry : need;
  assign out_has_data = grant && cst[req_idx][ra] == ST_I;
  assign out_data     = out_has_data ? mem[ra] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int a = 0; a < WORDS; a++) begin
        mem[a] <= '0;
        for (int c = 0; c < N; c++) begin
          cst[c][a] <= ST_I;
          wv[c][a]  <= 1'b0;
          wst[c][a] <= ST_I;
        end
      end
    end else if (rsp_hit) begin
      if (cst[rsp_idx][pa] == ST_M) mem[pa] <= pd;
      cst[rsp_idx][pa] <= py;
      if (wv[rsp_idx][pa] && wst[rsp_idx][pa] >= py) wv[rsp_idx][pa] <= 1'b0;
    end else if (req_hit) begin
      ptr <= (int'(req_idx) == N-1) ? '0 : req_idx + 1'b1;
      if (grant) cst[req_idx][ra] <= ry;
      else if (dn_hit) begin
        wv[dn_idx][ra]  <= 1'b1;
        wst[dn_idx][ra] <= need;
      end
    end
  end

  p_rsp_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> (req_ready == '0));
  p_one_deq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rsp_ready}));
  p_dn_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_grant) |=> wv[$past(out_dst)][$past(out_addr)]);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [N-1:0] mvec;
    for (genvar c = 0; c < N; c++) begin : g_ch
      assign mvec[c] = (cst[c][g] == ST_M);
    end
    p_one_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mvec) <= 1);
  end
endmodule

// File: tb/msi_home_dir_tb.sv
module msi_home_dir_tb_top;
  localparam int N = 4, AW = 4, DW = 32;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  ch;
    logic [3:0]  addr;
    logic [1:0]  st;
    logic [31:0] data;
    logic        ev;
    logic        eg;
    logic [1:0]  ed;
    logic [1:0]  es;
    logic        eh;
    logic [31:0] edat;
    logic [3:0]  rq;
  } vec_t;

  // kind: 1 request, 2 response. States I=0, S=1, M=2.
  localparam vec_t VECS [22] = '{
    '{2'd1,2'd0,4'd3,2'd2,32'h0,        1'b1,1'b1,2'd0,2'd2,1'b1,32'h0,        4'd2}, // R2 cold M
    '{2'd2,2'd0,4'd3,2'd0,32'hAAAA,     1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd5}, // R5 evict from M
    '{2'd1,2'd1,4'd3,2'd1,32'h0,        1'b1,1'b1,2'd1,2'd1,1'b1,32'hAAAA,     4'd1}, // R1
    '{2'd1,2'd2,4'd3,2'd1,32'h0,        1'b1,1'b1,2'd2,2'd1,1'b1,32'hAAAA,     4'd1}, // R1 S,S ok
    '{2'd1,2'd0,4'd3,2'd2,32'h0,        1'b1,1'b0,2'd1,2'd0,1'b0,32'h0,        4'd3}, // R3
    '{2'd1,2'd0,4'd3,2'd2,32'h0,        1'b1,1'b0,2'd2,2'd0,1'b0,32'h0,        4'd3}, // R3 skip waiting
    '{2'd1,2'd0,4'd3,2'd2,32'h0,        1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd4}, // R4
    '{2'd2,2'd1,4'd3,2'd0,32'hBEEF,     1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd6}, // R6
    '{2'd1,2'd0,4'd3,2'd2,32'h0,        1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd4}, // R4
    '{2'd2,2'd2,4'd3,2'd0,32'h0,        1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd6}, // R6
    '{2'd1,2'd0,4'd3,2'd2,32'h0,        1'b1,1'b1,2'd0,2'd2,1'b1,32'hAAAA,     4'd5}, // R5 no write from S
    '{2'd1,2'd1,4'd3,2'd1,32'h0,        1'b1,1'b0,2'd0,2'd1,1'b0,32'h0,        4'd3}, // R3 need S
    '{2'd2,2'd0,4'd3,2'd1,32'h5555,     1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd5}, // R5
    '{2'd1,2'd1,4'd3,2'd1,32'h0,        1'b1,1'b1,2'd1,2'd1,1'b1,32'h5555,     4'd5}, // R5 write seen
    '{2'd1,2'd2,4'd3,2'd2,32'h0,        1'b1,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd3}, // R3
    '{2'd2,2'd0,4'd3,2'd1,32'hDEAD,     1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd6}, // R6 x<y
    '{2'd1,2'd2,4'd3,2'd2,32'h0,        1'b1,1'b0,2'd1,2'd0,1'b0,32'h0,        4'd6}, // R6 wait kept
    '{2'd2,2'd0,4'd3,2'd0,32'h0,        1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd6}, // R6
    '{2'd2,2'd1,4'd3,2'd0,32'h0,        1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,        4'd6}, // R6
    '{2'd1,2'd2,4'd3,2'd2,32'h0,        1'b1,1'b1,2'd2,2'd2,1'b1,32'h5555,     4'd1}, // R1
    '{2'd1,2'd3,4'd5,2'd1,32'h0,        1'b1,1'b1,2'd3,2'd1,1'b1,32'h0,        4'd2}, // R2
    '{2'd1,2'd3,4'd5,2'd2,32'h0,        1'b1,1'b1,2'd3,2'd2,1'b0,32'h0,        4'd2}  // R2 no data S->M
  };

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid, req_ready, rsp_valid, rsp_ready;
  logic [N*AW-1:0] req_addr, rsp_addr;
  logic [2*N-1:0] req_state, rsp_state;
  logic [N*DW-1:0] rsp_data;
  logic out_valid, out_grant, out_has_data;
  logic [1:0] out_dst, out_state;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  msi_home_dir #(.N(N), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_state(req_state), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_state(rsp_state), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready),
    .out_valid(out_valid), .out_grant(out_grant), .out_dst(out_dst), .out_addr(out_addr),
    .out_state(out_state), .out_has_data(out_has_data), .out_data(out_data));

  task automatic clear_in();
    req_valid = '0; req_addr = '0; req_state = '0;
    rsp_valid = '0; rsp_addr = '0; rsp_state = '0; rsp_data = '0;
  endtask

  task automatic put_req(input int c, input logic [3:0] a, input logic [1:0] s);
    req_valid[c] = 1'b1; req_addr[c*AW +: AW] = a; req_state[c*2 +: 2] = s;
  endtask

  task automatic put_rsp(input int c, input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    rsp_valid[c] = 1'b1; rsp_addr[c*AW +: AW] = a; rsp_state[c*2 +: 2] = s; rsp_data[c*DW +: DW] = d;
  endtask

  task automatic expect_out(input int rq, input logic ev, input logic eg, input logic [1:0] ed,
                            input logic [1:0] es, input logic eh, input logic [31:0] edat);
    logic ok;
    checks++;
    ok = (out_valid == ev);
    if (ev) ok = ok && out_grant == eg && out_dst == ed && out_state == es &&
                 out_has_data == eh && out_data == edat;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: got v=%0b g=%0b d=%0d s=%0d h=%0b data=%h, expected v=%0b g=%0b d=%0d s=%0d h=%0b data=%h",
               rq, out_valid, out_grant, out_dst, out_state, out_has_data, out_data,
               ev, eg, ed, es, eh, edat);
    end
  endtask

  task automatic expect_ready(input int rq, input logic [N-1:0] eq, input logic [N-1:0] ep);
    checks++;
    if (req_ready != eq || rsp_ready != ep) begin
      fails++;
      $display("FAIL R%0d: req_ready=%b rsp_ready=%b, expected %b %b", rq, req_ready, rsp_ready, eq, ep);
    end
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    expect_out(10, 0, 0, 0, 0, 0, 0);                      // R10 idle
    @(negedge clk); clear_in(); put_req(0, 4'd9, 2'd1); #1;
    expect_out(10, 1, 1, 0, 2'd1, 1, 32'h0);                // R10 word zero, record I

    foreach (VECS[i]) begin
      @(negedge clk); clear_in();
      if (VECS[i].kind == 2'd1) put_req(int'(VECS[i].ch), VECS[i].addr, VECS[i].st);
      else put_rsp(int'(VECS[i].ch), VECS[i].addr, VECS[i].st, VECS[i].data);
      #1;
      expect_out(int'(VECS[i].rq), VECS[i].ev, VECS[i].eg, VECS[i].ed, VECS[i].es,
                 VECS[i].eh, VECS[i].edat);
    end

    // R7: response beats a waiting request; child 3 holds word 5 in M
    @(negedge clk); clear_in(); put_rsp(3, 4'd5, 2'd0, 32'h1234); put_req(1, 4'd6, 2'd1); #1;
    expect_ready(7, 4'b0000, 4'b1000);
    expect_out(7, 0, 0, 0, 0, 0, 0);
    @(negedge clk); clear_in(); put_req(1, 4'd6, 2'd1); #1;
    expect_out(7, 1, 1, 2'd1, 2'd1, 1, 32'h0);
    @(negedge clk); clear_in(); put_req(0, 4'd5, 2'd1); #1;
    expect_out(5, 1, 1, 2'd0, 2'd1, 1, 32'h1234);           // R5 M write-back stored

    // R8: pointer now at child 1
    @(negedge clk); clear_in(); put_req(1, 4'd7, 2'd1); put_req(2, 4'd8, 2'd1); #1;
    expect_ready(8, 4'b0010, 4'b0000);
    @(negedge clk); clear_in(); put_req(1, 4'd10, 2'd1); put_req(2, 4'd8, 2'd1); #1;
    expect_ready(8, 4'b0100, 4'b0000);
    expect_out(8, 1, 1, 2'd2, 2'd1, 1, 32'h0);

    @(negedge clk); clear_in();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule